// File: doc/BRIEF.md
# PCI INTx to ISA IRQ Router

This block takes four active-high PCI interrupt request lines and steers each of them onto one of sixteen ISA interrupt lines. Which line is used depends on a byte-wide routing register per request line. The four routing bytes live in one 32-bit configuration dword at byte offset 0x60. Software reaches them through a byte-enabled write port and a combinational read port.

A routing byte below 16 names the ISA line that the request drives. A byte of 16 or above takes that request off every line. Several requests may share one ISA line; the line is then the OR of them. The ISA outputs come from a registered level map of 16 lines by 4 requests, so they follow both input changes and routing changes with one clock of latency. A separate query port reports, for any request index, whether it is routed and to which line.

Top module: `pirq_isa_router`

## Requirements
- R1: The routing byte for request p (p = 0..3) sits in byte lane p of the dword whose address bits [7:2] equal 0x60>>2; `cfg_addr[1:0]` are ignored. Byte lane p is `cfg_wdata`/`cfg_rdata` bits [8p+7:8p], and its enable is `cfg_be[p]`.
- R2: A routing byte with value v < 16 routes its request to ISA line v. Any v >= 16 (any of bits 7:4 set) routes it to no line.
- R3: `isa_irq[n]` is the OR of `pirq_in[p]` over every request p whose routing byte equals n. A change on `pirq_in` shows on `isa_irq` after the next rising clock edge and not before it.
- R4: A routing write committed at one rising edge shows on `isa_irq` after the following rising edge. The new map is built from the live `pirq_in` levels and all four current routing bytes.
- R5: A write to the routing dword updates only the lanes whose `cfg_be` bit is 1; the other lanes keep their value.
- R6: A write to any other dword changes neither the routing bytes nor `isa_irq`. A read of any other dword returns 0.
- R7: A read of the routing dword returns all four stored bytes unchanged, bits 6:4 included.
- R8: The query port gives `qry_en`=1 and `qry_irq`=routing byte when the byte of request `qry_pirq` is below 16. Otherwise it gives `qry_en`=0 and `qry_irq`=8'hFF. It is combinational.
- R9: An asynchronous active-low reset sets every routing byte to 0x80 (all requests unrouted) and drives every `isa_irq` bit low at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte address (dword-aligned use) |
| cfg_be | input | 4 | Byte-lane write enables |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data for `cfg_addr` |
| pirq_in | input | 4 | PCI interrupt request levels, active high |
| isa_irq | output | 16 | ISA interrupt line levels |
| qry_pirq | input | 2 | Request index to query |
| qry_en | output | 1 | Queried request is routed |
| qry_irq | output | 8 | Routed line number, or 8'hFF when unrouted |

## Verification
The bench sweeps every request through every line number and through several values at or above 16. For each setting it applies all sixteen input patterns. A design that compared only the low nibble would light a line for 0x80 or 0x1F, and one that tested only bit 7 would route 0x10 to line 0. Tests with all requests on one line and with pseudo-random sharing catch a fabric that overwrites instead of ORing. Latency probes around the write edge and the input edge catch outputs that are one cycle early or late. Partial byte enables and writes to a neighbouring dword catch lanes that get clobbered. A reset taken while lines are active checks that the outputs drop at once and do not wait for a clock.

// File: rtl/pirq_rt_pkg.sv
package pirq_rt_pkg;
  localparam int unsigned ROUTE_W   = 8;
  localparam int unsigned NUM_PIRQ  = 4;
  localparam int unsigned NUM_IRQ   = 16;
  localparam logic [ROUTE_W-1:0] ROUTE_OFF = 8'h80;
endpackage

// File: rtl/pirq_cfg_regs.sv
module pirq_cfg_regs
  import pirq_rt_pkg::*;
#(
  parameter int unsigned N_PIRQ = NUM_PIRQ,
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE = 8'h60
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr,
  input  logic [ADDR_W-1:0]                 addr,
  input  logic [N_PIRQ-1:0]                 be,
  input  logic [N_PIRQ*ROUTE_W-1:0]         wdata,
  output logic [N_PIRQ*ROUTE_W-1:0]         rdata,
  output logic [N_PIRQ-1:0][ROUTE_W-1:0]    route_q
);
  localparam int unsigned LANE_W = $clog2(N_PIRQ);

  logic                           hit;
  logic                           route_we;
  logic [N_PIRQ-1:0][ROUTE_W-1:0] route_d;

  assign hit      = (addr[ADDR_W-1:LANE_W] == BASE[ADDR_W-1:LANE_W]);
  assign route_we = wr && hit && (|be);

  always_comb begin
    route_d = route_q;
    for (int i = 0; i < int'(N_PIRQ); i++) begin
      if (be[i]) route_d[i] = wdata[i*ROUTE_W +: ROUTE_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(N_PIRQ); i++) route_q[i] <= ROUTE_OFF;
    end else if (route_we) begin
      route_q <= route_d;
    end
  end

  assign rdata = hit ? route_q : '0;

  // R6: writes elsewhere leave the routing bytes alone
  a_r6_foreign_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !hit) |=> $stable(route_q));

  for (genvar g = 0; g < int'(N_PIRQ); g++) begin : g_lane_chk
    // R5: a disabled lane keeps its byte
    a_r5_lane_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (!(wr && be[g])) |=> $stable(route_q[g]));
  end
endmodule

// File: rtl/pirq_route_fabric.sv
module pirq_route_fabric
  import pirq_rt_pkg::*;
#(
  parameter int unsigned N_PIRQ = NUM_PIRQ,
  parameter int unsigned N_IRQ  = NUM_IRQ
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [N_PIRQ-1:0]              pirq_in,
  input  logic [N_PIRQ-1:0][ROUTE_W-1:0] route_q,
  output logic [N_IRQ-1:0]               isa_irq
);
  localparam logic [ROUTE_W-1:0] LIMIT = ROUTE_W'(N_IRQ);

  logic [N_PIRQ-1:0]             route_ok;
  logic [N_IRQ-1:0][N_PIRQ-1:0]  map_d;
  logic [N_IRQ-1:0][N_PIRQ-1:0]  map_q;
  logic [N_PIRQ-1:0][N_IRQ-1:0]  map_col;
  logic                          map_we;

  assign map_we = 1'b1;

  for (genvar p = 0; p < int'(N_PIRQ); p++) begin : g_pirq
    assign route_ok[p] = (route_q[p] < LIMIT);
    for (genvar n = 0; n < int'(N_IRQ); n++) begin : g_irq
      assign map_d[n][p]   = pirq_in[p] && route_ok[p] &&
                             (route_q[p] == ROUTE_W'(n));
      assign map_col[p][n] = map_q[n][p];
    end
    // R2: a request sits on at most one line
    a_r2_one_line: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(map_col[p]));
    // R2: an unrouted request leaves no trace in the map
    a_r2_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (route_q[p] >= LIMIT) |=> (map_col[p] == '0));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      map_q <= '0;
    else if (map_we) map_q <= map_d;
  end

  for (genvar n = 0; n < int'(N_IRQ); n++) begin : g_out
    assign isa_irq[n] = |map_q[n];
  end

  // R3: a line can only be high if some request was high a cycle earlier
  a_r3_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
    (isa_irq != '0) |-> $past(pirq_in != '0));
endmodule

// File: rtl/pirq_route_query.sv
module pirq_route_query
  import pirq_rt_pkg::*;
#(
  parameter int unsigned N_PIRQ = NUM_PIRQ,
  parameter int unsigned N_IRQ  = NUM_IRQ
) (
  input  logic [$clog2(N_PIRQ)-1:0]      sel,
  input  logic [N_PIRQ-1:0][ROUTE_W-1:0] route_q,
  output logic                           en,
  output logic [ROUTE_W-1:0]             irq
);
  localparam logic [ROUTE_W-1:0] LIMIT = ROUTE_W'(N_IRQ);

  logic [ROUTE_W-1:0] byte_sel;

  always_comb begin
    byte_sel = route_q[sel];
    en       = (byte_sel < LIMIT);
    irq      = en ? byte_sel : '1;
  end
endmodule

// File: rtl/pirq_isa_router.sv
module pirq_isa_router
  import pirq_rt_pkg::*;
#(
  parameter int unsigned N_PIRQ = NUM_PIRQ,
  parameter int unsigned N_IRQ  = NUM_IRQ,
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE = 8'h60
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_wr,
  input  logic [ADDR_W-1:0]           cfg_addr,
  input  logic [N_PIRQ-1:0]           cfg_be,
  input  logic [N_PIRQ*ROUTE_W-1:0]   cfg_wdata,
  output logic [N_PIRQ*ROUTE_W-1:0]   cfg_rdata,
  input  logic [N_PIRQ-1:0]           pirq_in,
  output logic [N_IRQ-1:0]            isa_irq,
  input  logic [$clog2(N_PIRQ)-1:0]   qry_pirq,
  output logic                        qry_en,
  output logic [ROUTE_W-1:0]          qry_irq
);
  logic [N_PIRQ-1:0][ROUTE_W-1:0] route_q;

  pirq_cfg_regs #(.N_PIRQ(N_PIRQ), .ADDR_W(ADDR_W), .BASE(BASE)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .addr(cfg_addr), .be(cfg_be),
    .wdata(cfg_wdata), .rdata(cfg_rdata), .route_q(route_q)
  );

  pirq_route_fabric #(.N_PIRQ(N_PIRQ), .N_IRQ(N_IRQ)) u_fabric (
    .clk(clk), .rst_n(rst_n), .pirq_in(pirq_in), .route_q(route_q),
    .isa_irq(isa_irq)
  );

  pirq_route_query #(.N_PIRQ(N_PIRQ), .N_IRQ(N_IRQ)) u_query (
    .sel(qry_pirq), .route_q(route_q), .en(qry_en), .irq(qry_irq)
  );

  // R8: an enabled answer is always a real line number
  a_r8_query_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    qry_en |-> (qry_irq < ROUTE_W'(N_IRQ)));
  // R8: a disabled answer reports all ones
  a_r8_query_off_ones: assert property (@(posedge clk) disable iff (!rst_n)
    !qry_en |-> (qry_irq == '1));
  // R4: with every request off, the lines are low one cycle later
  a_r4_all_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (qry_en == 1'b0 && route_q == {N_PIRQ{ROUTE_OFF}}) |=> (isa_irq == '0));
endmodule

// File: tb/pirq_isa_router_test.sv
`timescale 1ns/1ps
module pirq_isa_router_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr;
  logic [7:0]  cfg_addr;
  logic [3:0]  cfg_be;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic [3:0]  pirq_in;
  logic [15:0] isa_irq;
  logic [1:0]  qry_pirq;
  logic        qry_en;
  logic [7:0]  qry_irq;

  int unsigned vectors = 0;
  int unsigned fails   = 0;
  bit          done    = 1'b0;
  logic [31:0] model;

  always #5 clk = ~clk;

  pirq_isa_router uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .pirq_in(pirq_in), .isa_irq(isa_irq), .qry_pirq(qry_pirq),
    .qry_en(qry_en), .qry_irq(qry_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_isa(input logic [31:0] r, input logic [3:0] pin);
    logic [15:0] e = '0;
    for (int p = 0; p < 4; p++) begin
      logic [7:0] b = r[p*8 +: 8];
      if (b < 8'd16 && pin[p]) e[b[3:0]] = 1'b1;
    end
    return e;
  endfunction

  task automatic write_cfg(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d; cfg_be = be;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_addr = 8'h60;
  endtask

  // Set routes and inputs together, then check lines and query after settling.
  task automatic apply(input logic [31:0] r, input logic [3:0] pin, input string req);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = 8'h60; cfg_wdata = r; cfg_be = 4'hF; pirq_in = pin;
    @(negedge clk);
    cfg_wr = 1'b0;
    model = r;
    @(negedge clk);
    chk(req, {16'h0, isa_irq}, {16'h0, exp_isa(model, pin)});
  endtask

  task automatic check_query(input string req);
    for (int q = 0; q < 4; q++) begin
      logic [7:0] b = model[q*8 +: 8];
      qry_pirq = 2'(q);
      #1;
      chk(req, {23'h0, qry_en, qry_irq},
          {23'h0, (b < 8'd16), (b < 8'd16) ? b : 8'hFF});
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] lf;
    logic [7:0]  vals [0:3];
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_addr = 8'h60; cfg_be = '0;
    cfg_wdata = '0; pirq_in = '0; qry_pirq = '0;
    model = 32'h80808080;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 reset lines", {16'h0, isa_irq}, 32'h0);
    chk("R9 reset bytes", cfg_rdata, 32'h80808080);
    rst_n = 1'b1;
    @(negedge clk);
    check_query("R8 reset query");

    // R2 R3 R8: sweep each request through every line and several off values
    vals[0] = 8'h10; vals[1] = 8'h80; vals[2] = 8'hFF; vals[3] = 8'h7F;
    for (int p = 0; p < 4; p++) begin
      for (int v = 0; v < 20; v++) begin
        logic [31:0] r = 32'h80808080;
        logic [7:0]  b = (v < 16) ? 8'(v) : vals[v-16];
        r[p*8 +: 8] = b;
        for (int pat = 0; pat < 16; pat++) apply(r, 4'(pat), "R2 sweep");
        check_query("R8 sweep query");
      end
    end

    // R3: all four share one line, OR behaviour
    for (int pat = 0; pat < 16; pat++) apply(32'h05050505, 4'(pat), "R3 shared OR");

    // R3: input latency, one edge
    apply(32'h03020100, 4'h0, "R3 base");
    @(negedge clk);
    pirq_in = 4'hA;
    #1 chk("R3 no early change", {16'h0, isa_irq}, 32'h0);
    @(negedge clk);
    chk("R3 after one edge", {16'h0, isa_irq}, {16'h0, exp_isa(model, 4'hA)});

    // R4: routing write latency, live levels
    @(negedge clk);
    cfg_wr = 1'b1; cfg_wdata = 32'h0C0B0A09; cfg_be = 4'hF;
    @(negedge clk);
    cfg_wr = 1'b0;
    chk("R4 old route held", {16'h0, isa_irq}, {16'h0, exp_isa(32'h03020100, 4'hA)});
    model = 32'h0C0B0A09;
    @(negedge clk);
    chk("R4 new route", {16'h0, isa_irq}, {16'h0, exp_isa(model, 4'hA)});

    // R5: partial byte enables
    write_cfg(8'h60, 32'h11223344, 4'b0101);
    model = 32'h0C220A44;
    #1 chk("R5 lanes", cfg_rdata, model);
    write_cfg(8'h62, 32'h0F000000, 4'b1000);
    model = 32'h0F220A44;
    #1 chk("R5 addr low bits ignored", cfg_rdata, model);

    // R7: upper bits stored
    write_cfg(8'h60, 32'h7F4F3A21, 4'hF);
    model = 32'h7F4F3A21;
    #1 chk("R7 readback", cfg_rdata, model);
    check_query("R8 wide bytes");

    // R6: foreign dword ignored
    apply(32'h01000302, 4'hF, "R6 base");
    write_cfg(8'h64, 32'h00000000, 4'hF);
    #1 chk("R6 bytes kept", cfg_rdata, 32'h01000302);
    @(negedge clk);
    chk("R6 lines kept", {16'h0, isa_irq}, {16'h0, exp_isa(32'h01000302, 4'hF)});
    cfg_addr = 8'h64;
    #1 chk("R6 foreign read", cfg_rdata, 32'h0);
    cfg_addr = 8'h5C;
    #1 chk("R6 foreign read low", cfg_rdata, 32'h0);
    cfg_addr = 8'h60;

    // R1 R3: pseudo-random routing with sharing
    lf = 32'h1ACE_B00C;
    for (int k = 0; k < 96; k++) begin
      logic [31:0] r;
      lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
      r = (k % 4 == 3) ? lf : (lf & 32'h1F1F1F1F);
      for (int pat = 0; pat < 16; pat += 5) apply(r, 4'(pat), "R1 random");
      #1 chk("R1 readback", cfg_rdata, r);
      check_query("R8 random query");
    end

    // R9: asynchronous reset while lines active
    apply(32'h00000000, 4'hF, "R9 pre");
    #2 rst_n = 1'b0;
    #1 chk("R9 async lines", {16'h0, isa_irq}, 32'h0);
    chk("R9 async bytes", cfg_rdata, 32'h80808080);
    @(negedge clk);
    rst_n = 1'b1;
    model = 32'h80808080;
    @(negedge clk);
    chk("R9 stays off", {16'h0, isa_irq}, 32'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule